// File: doc/BRIEF.md
# Completion Signal Timeout Timer

This block guards a host controller for memory cards and ATA-style devices against a device that never reports completion. It counts clock cycles from a start event to the moment the device raises its completion signal. When the count passes a programmed limit first, it sets an error flag. The flag stays set until the host clears it.

The limit is set by a small configuration register. A 4-bit cycle count is scaled by a power-of-two multiplier, and a 3-bit code selects that multiplier. The start event depends on the command type. For a command that moves data, counting starts once the data transfer is over, and the transfer includes any busy phase the device signals. For a non-data ATA command, counting starts at the end of the response. A new start event restarts the count from zero with the register contents present at that moment.

Top module: `cmpl_tmo_timer`

## Requirements
- R1: The timeout limit L equals the cycle-count field times the selected multiplier, computed at full width (24 bits by default). The error flag is still low after the L-th rising edge that follows the start edge, and it is high after the (L+1)-th edge if no completion arrived.
- R2: The register is written through `cfg_wdata`, with the cycle count in bits 3:0 and the multiplier code in bits 6:4. `cfg_rdata` returns those seven bits and reads bit 7 as zero.
- R3: Multiplier codes 0, 1, 2, 3, 4, 5, 6 and 7 give the multipliers 1, 16, 128, 256, 1024, 4096, 65536 and 1048576.
- R4: A pulse on `xfer_end` starts counting if `busy_active` is low in that cycle. If `busy_active` is high, the start waits until the first cycle in which `busy_active` is low.
- R5: A pulse on `resp_end` starts counting while `nodata_cmd` is high. A pulse on `resp_end` while `nodata_cmd` is low has no effect.
- R6: If `cmpl_sig` is high at any edge while counting, counting stops and no error is raised. This includes the edge at which the timeout would have fired, so completion wins over timeout.
- R7: `tmo_err` stays set until a pulse on `err_clr`. When a timeout and a clear occur in the same cycle, the flag ends up set.
- R8: A start event that occurs while counting restarts the count from zero. A start event never clears `tmo_err`.
- R9: A cycle count of zero raises the error at the first edge after the start edge.
- R10: A register write made while counting has no effect on the running limit. The written value applies from the next start event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 7 | Write data: [6:4] multiplier code, [3:0] cycle count |
| cfg_rdata | output | 8 | Register read value, bit 7 reads as zero |
| xfer_end | input | 1 | Pulse at the end of the data phase |
| busy_active | input | 1 | High while the device signals busy after data |
| nodata_cmd | input | 1 | High while the current command is a non-data ATA command |
| resp_end | input | 1 | Pulse at the end of the command response |
| cmpl_sig | input | 1 | Completion signal from the device |
| err_clr | input | 1 | Pulse that clears the error flag |
| tmo_err | output | 1 | Sticky completion timeout error flag |

## Verification
If the latched limit or the count is wrong, `tmo_err` rises one or more cycles away from the exact (L+1)-th edge. The bench samples the flag both at L and at L+1, so an off-by-one error fails at once, for every multiplier code up to 65536. If the pending-start state is wrong, an error appears while `busy_active` is still high, or no error appears one edge after busy drops. If the run state is wrong, a completion fails to stop the count, and the error shows up tens of cycles later within the same scenario.

// File: rtl/cmpl_tmo_pkg.sv
package cmpl_tmo_pkg;
  localparam int CYC_W      = 4;
  localparam int SEL_W      = 3;
  localparam int FLD_W      = CYC_W + SEL_W;
  localparam int RD_W       = 8;
  localparam int CNT_W_DFLT = 24;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [CYC_W-1:0] cyc;
  } tmo_cfg_t;

  // Power-of-two exponent selected by the multiplier code.
  function automatic int unsigned mult_shift(input logic [SEL_W-1:0] code);
    int unsigned s;
    case (code)
      3'd0:    s = 0;
      3'd1:    s = 4;
      3'd2:    s = 7;
      3'd3:    s = 8;
      3'd4:    s = 10;
      3'd5:    s = 12;
      3'd6:    s = 16;
      default: s = 20;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/cmpl_tmo_cfg.sv
module cmpl_tmo_cfg
  import cmpl_tmo_pkg::*;
#(
  parameter int RDW = RD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [FLD_W-1:0] wdata,
  output tmo_cfg_t         cfg,
  output logic [RDW-1:0]   rdata
);
  localparam int PAD_W = RDW - FLD_W;

  tmo_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= tmo_cfg_t'(wdata);
  end

  assign cfg   = cfg_q;
  assign rdata = {{PAD_W{1'b0}}, cfg_q};
endmodule

// File: rtl/cmpl_tmo_start.sv
module cmpl_tmo_start (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_end,
  input  logic busy_active,
  input  logic nodata_cmd,
  input  logic resp_end,
  output logic start_evt,
  output logic pend_q
);
  logic data_start;
  logic nd_start;

  // A data start is held back while the device reports busy.
  assign data_start = (xfer_end | pend_q) & ~busy_active;
  assign nd_start   = resp_end & nodata_cmd;
  assign start_evt  = data_start | nd_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pend_q <= 1'b0;
    else if (data_start)              pend_q <= 1'b0;
    else if (xfer_end && busy_active) pend_q <= 1'b1;
  end
endmodule

// File: rtl/cmpl_tmo_count.sv
module cmpl_tmo_count
  import cmpl_tmo_pkg::*;
#(
  parameter int CNT_W = CNT_W_DFLT
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_evt,
  input  tmo_cfg_t cfg,
  input  logic     cmpl_sig,
  output logic     run_q,
  output logic     tmo_hit
);
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_new;

  function automatic logic [CNT_W-1:0] limit_of(input tmo_cfg_t c);
    return CNT_W'(c.cyc) << mult_shift(c.sel);
  endfunction

  assign lim_new = limit_of(cfg);
  // Timeout fires only when neither a restart nor a completion claims the cycle.
  assign tmo_hit = run_q & ~start_evt & ~cmpl_sig & (cnt_q >= lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_evt) begin
      lim_q <= lim_new;
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cmpl_sig || tmo_hit) run_q <= 1'b0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cmpl_tmo_err.sv
module cmpl_tmo_err (
  input  logic clk,
  input  logic rst_n,
  input  logic tmo_hit,
  input  logic err_clr,
  output logic tmo_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tmo_err <= 1'b0;
    else if (tmo_hit) tmo_err <= 1'b1;
    else if (err_clr) tmo_err <= 1'b0;
  end
endmodule

// File: rtl/cmpl_tmo_timer.sv
module cmpl_tmo_timer
  import cmpl_tmo_pkg::*;
#(
  parameter int CNT_W = CNT_W_DFLT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [FLD_W-1:0] cfg_wdata,
  output logic [RD_W-1:0]  cfg_rdata,
  input  logic             xfer_end,
  input  logic             busy_active,
  input  logic             nodata_cmd,
  input  logic             resp_end,
  input  logic             cmpl_sig,
  input  logic             err_clr,
  output logic             tmo_err
);
  tmo_cfg_t cfg;
  logic     start_evt;
  logic     pend_q;
  logic     run_q;
  logic     tmo_hit;

  cmpl_tmo_cfg #(.RDW(RD_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .rdata(cfg_rdata)
  );

  cmpl_tmo_start start_i (
    .clk(clk), .rst_n(rst_n), .xfer_end(xfer_end), .busy_active(busy_active),
    .nodata_cmd(nodata_cmd), .resp_end(resp_end),
    .start_evt(start_evt), .pend_q(pend_q)
  );

  cmpl_tmo_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .cfg(cfg),
    .cmpl_sig(cmpl_sig), .run_q(run_q), .tmo_hit(tmo_hit)
  );

  cmpl_tmo_err err_i (
    .clk(clk), .rst_n(rst_n), .tmo_hit(tmo_hit), .err_clr(err_clr),
    .tmo_err(tmo_err)
  );
endmodule

// File: rtl/cmpl_tmo_chk.sv
module cmpl_tmo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_rdata,
  input logic       start_evt,
  input logic       pend_q,
  input logic       busy_active,
  input logic       run_q,
  input logic       tmo_hit,
  input logic       cmpl_sig,
  input logic       err_clr,
  input logic       tmo_err
);
  AST_RDATA_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7] == 1'b0); // R2
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> run_q); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_active |-> !(pend_q && start_evt) || !busy_active); // R4
  AST_PEND_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && busy_active) |=> pend_q || start_evt || !busy_active); // R4
  AST_CMPL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cmpl_sig && !start_evt) |=> !run_q); // R6
  AST_CMPL_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_sig |-> !tmo_hit); // R6
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !tmo_hit); // R1
  AST_HIT_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> tmo_err); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_err && !err_clr) |=> tmo_err); // R7
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !tmo_hit) |=> !tmo_err); // R7
endmodule

bind cmpl_tmo_timer cmpl_tmo_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .start_evt(start_evt),
  .pend_q(pend_q), .busy_active(busy_active), .run_q(run_q),
  .tmo_hit(tmo_hit), .cmpl_sig(cmpl_sig), .err_clr(err_clr),
  .tmo_err(tmo_err)
);

// File: tb/cmpl_tmo_timer_tb.sv
module cmpl_tmo_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       xfer_end = 1'b0;
  logic       busy_active = 1'b0;
  logic       nodata_cmd = 1'b0;
  logic       resp_end = 1'b0;
  logic       cmpl_sig = 1'b0;
  logic       err_clr = 1'b0;
  logic       tmo_err;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cmpl_tmo_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .xfer_end(xfer_end), .busy_active(busy_active),
    .nodata_cmd(nodata_cmd), .resp_end(resp_end), .cmpl_sig(cmpl_sig),
    .err_clr(err_clr), .tmo_err(tmo_err)
  );

  function automatic int mult_ref(input int code);
    case (code)
      0: return 1;        1: return 16;     2: return 128;    3: return 256;
      4: return 1024;     5: return 4096;   6: return 65536;  default: return 1048576;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input int cyc, input int code);
    cfg_we = 1'b1; cfg_wdata = 7'((code << 4) | cyc);
    wait_cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_xfer;
    xfer_end = 1'b1; wait_cyc(1); xfer_end = 1'b0;
  endtask

  task automatic clear_err;
    err_clr = 1'b1; wait_cyc(1); err_clr = 1'b0;
  endtask

  task automatic t_reset;
    chk(tmo_err == 1'b0, "R7 reset err", tmo_err, 0);
    chk(cfg_rdata == 8'h00, "R2 reset rdata", cfg_rdata, 0);
  endtask

  task automatic t_regs;
    set_cfg(15, 7);
    chk(cfg_rdata == 8'h7F, "R2 rdata all ones", cfg_rdata, 8'h7F);
    set_cfg(9, 5);
    chk(cfg_rdata == 8'h59, "R2 rdata fields", cfg_rdata, 8'h59);
  endtask

  // Timeout lands exactly on edge L+1 after the start edge.
  task automatic t_limit(input int cyc, input int code, input string req);
    int lim;
    lim = cyc * mult_ref(code);
    clear_err();
    set_cfg(cyc, code);
    pulse_xfer();
    wait_cyc(lim);
    chk(tmo_err == 1'b0, req, tmo_err, 0);
    wait_cyc(1);
    chk(tmo_err == 1'b1, req, tmo_err, 1);
  endtask

  task automatic t_completion;
    clear_err();
    set_cfg(1, 1);
    pulse_xfer();
    wait_cyc(10);
    cmpl_sig = 1'b1; wait_cyc(1); cmpl_sig = 1'b0;
    wait_cyc(40);
    chk(tmo_err == 1'b0, "R6 completion mid-run", tmo_err, 0);
    pulse_xfer();
    wait_cyc(16);
    cmpl_sig = 1'b1; wait_cyc(1); cmpl_sig = 1'b0;
    wait_cyc(5);
    chk(tmo_err == 1'b0, "R6 completion at last edge", tmo_err, 0);
  endtask

  task automatic t_busy;
    clear_err();
    set_cfg(0, 0);
    busy_active = 1'b1;
    pulse_xfer();
    wait_cyc(20);
    chk(tmo_err == 1'b0, "R4 held while busy", tmo_err, 0);
    busy_active = 1'b0;
    wait_cyc(1);
    chk(tmo_err == 1'b0, "R4 start edge", tmo_err, 0);
    wait_cyc(1);
    chk(tmo_err == 1'b1, "R4 timeout after busy", tmo_err, 1);
  endtask

  task automatic t_nodata;
    clear_err();
    set_cfg(0, 0);
    resp_end = 1'b1; wait_cyc(1); resp_end = 1'b0;
    wait_cyc(10);
    chk(tmo_err == 1'b0, "R5 resp_end ignored for data cmd", tmo_err, 0);
    nodata_cmd = 1'b1;
    resp_end = 1'b1; wait_cyc(1); resp_end = 1'b0;
    chk(tmo_err == 1'b0, "R5 start edge", tmo_err, 0);
    wait_cyc(1);
    chk(tmo_err == 1'b1, "R5 non-data timeout", tmo_err, 1);
    nodata_cmd = 1'b0;
  endtask

  task automatic t_midwrite;
    clear_err();
    set_cfg(1, 1);
    pulse_xfer();
    wait_cyc(4);
    set_cfg(0, 0);
    wait_cyc(11);
    chk(tmo_err == 1'b0, "R10 write ignored while running", tmo_err, 0);
    wait_cyc(1);
    chk(tmo_err == 1'b1, "R10 old limit used", tmo_err, 1);
    clear_err();
    pulse_xfer();
    wait_cyc(1);
    chk(tmo_err == 1'b1, "R10 new limit on next start", tmo_err, 1);
  endtask

  task automatic t_restart;
    clear_err();
    set_cfg(1, 1);
    pulse_xfer();
    wait_cyc(10);
    pulse_xfer();
    wait_cyc(16);
    chk(tmo_err == 1'b0, "R8 restart from zero", tmo_err, 0);
    wait_cyc(1);
    chk(tmo_err == 1'b1, "R8 timeout after restart", tmo_err, 1);
    pulse_xfer();
    wait_cyc(5);
    chk(tmo_err == 1'b1, "R8 start keeps err", tmo_err, 1);
    wait_cyc(20);
  endtask

  task automatic t_sticky;
    wait_cyc(50);
    chk(tmo_err == 1'b1, "R7 sticky", tmo_err, 1);
    clear_err();
    chk(tmo_err == 1'b0, "R7 clear", tmo_err, 0);
    set_cfg(0, 0);
    pulse_xfer();
    err_clr = 1'b1; wait_cyc(1); err_clr = 1'b0;
    chk(tmo_err == 1'b1, "R7 set wins over clear", tmo_err, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_regs();
    t_limit(0, 3, "R9 zero count");
    t_limit(5, 0, "R1 code0");
    t_limit(2, 1, "R3 code1");
    t_limit(1, 2, "R3 code2");
    t_limit(1, 3, "R3 code3");
    t_limit(3, 4, "R3 code4");
    t_limit(1, 5, "R3 code5");
    t_limit(1, 6, "R3 code6");
    t_completion();
    t_busy();
    t_nodata();
    t_midwrite();
    t_restart();
    t_sticky();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule